// File: doc/BRIEF.md
# Interleaved I/Q Parallel Input Assembler

This block sits at the parallel sample port of a digital upconverter. It produces a one-cycle data-clock enable from a programmable divide of the system clock. It captures one signed 14-bit word on each enable and sorts the words into I and Q halves. It then presents a registered I/Q pair together with a one-cycle valid strobe. In quadrature mode the port carries I and Q words in turn, so the enable runs at twice the pair rate. In interpolating mode only I words arrive, one per enable, and Q is forced to zero.

A transmit-enable input gates capture. While it is low the port is ignored and zero pairs are sent downstream at the normal pair cadence, which flushes the datapath. Each new enable window starts on an I word. If an I word is still waiting for its Q partner when the window closes, that word is dropped and a one-cycle error flag is raised. The data-clock enable can optionally be held off until an external PLL reports lock.

Top module: `iq_input_assembler`

## Requirements
- R1: `dclk_en` is high for exactly one cycle in every `div_ratio`+1 system cycles (`div_ratio` ≥ 1, held constant between resets). The divider counter keeps running while the lock gate blocks `dclk_en`.
- R2: While `lock_qual` is 1 and `pll_locked` is 0, `dclk_en` stays low. While `lock_qual` is 0, `pll_locked` has no effect on `dclk_en`.
- R3: In quadrature mode (`mode_quad`=1) with `tx_en` high, the word on `din` at a `dclk_en` cycle is an I word or a Q word, in alternation. The cycle after each Q capture, `pair_vld` is 1 for one cycle, with `pair_i` holding the preceding I word and `pair_q` holding the Q word.
- R4: The first word captured after `tx_en` has been sampled low for at least one cycle is always taken as I, including when the previous window ended on an unpaired I.
- R5: In interpolating mode (`mode_quad`=0) with `tx_en` high, every `dclk_en` cycle yields `pair_vld`=1 on the next cycle, with `pair_i` equal to the captured word and `pair_q`=0.
- R6: While `tx_en` is low, `din` is ignored. Zero pairs (`pair_i`=`pair_q`=0, `pair_vld`=1) are emitted on every second `dclk_en` in quadrature mode and on every `dclk_en` in interpolating mode.
- R7: If `tx_en` is sampled low while an I word is waiting for its Q word, that I word is never output, and `pair_err` is 1 for exactly the following cycle.
- R8: `pair_i` and `pair_q` change only in a cycle in which `pair_vld` is 1. Otherwise they hold their values.
- R9: During reset, `dclk_en`, `pair_vld`, `pair_err`, `pair_i` and `pair_q` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| div_ratio | input | 6 | Data-clock period minus one, in system cycles |
| lock_qual | input | 1 | Hold the data clock until PLL lock |
| pll_locked | input | 1 | PLL lock indication |
| mode_quad | input | 1 | 1 = interleaved I/Q, 0 = I only |
| tx_en | input | 1 | Transmit enable, gates capture |
| din | input | 14 | Parallel port word, two's complement |
| dclk_en | output | 1 | Data-clock enable; a word is latched in this cycle |
| pair_i | output | 14 | Registered I sample |
| pair_q | output | 14 | Registered Q sample |
| pair_vld | output | 1 | One-cycle strobe for a new pair |
| pair_err | output | 1 | One-cycle flag: an unpaired I word was dropped |

## Verification
The bench goes after short enable windows that hold an odd number of words. A design that kept the stray I word would pair it with the first word of the next window, which shifts every later pair by half a sample and swaps I with Q. It also watches the flush cadence while transmit is disabled: a design that emitted a zero pair on every tick in quadrature mode would double the pair rate. A design that let port data through during the flush would inject noise into the downstream filters. Spans with the lock gate closed, and mode changes between windows, catch enables that leak out before lock or a Q path that is not forced to zero.

// File: rtl/iqa_pkg.sv
package iqa_pkg;
  typedef enum logic {
    SLOT_I = 1'b0,
    SLOT_Q = 1'b1
  } iqa_slot_e;
endpackage

// File: rtl/iqa_clkgen.sv
module iqa_clkgen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_ratio,
  input  logic             lock_qual,
  input  logic             pll_locked,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             wrap;
  logic             gate_open;

  always_comb begin
    wrap      = (cnt_q >= div_ratio);
    gate_open = !lock_qual || pll_locked;
    cnt_d     = wrap ? '0 : cnt_q + 1'b1;
    tick_o    = wrap && gate_open;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R1: a wrap is never followed by another wrap when the ratio is nonzero
  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && div_ratio != '0 && $stable(div_ratio)) |=> !wrap);

  // R2: the enable never leaks while the lock gate is closed
  assert_lock_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_qual && !pll_locked) |-> !tick_o);
endmodule

// File: rtl/iqa_demux.sv
module iqa_demux
  import iqa_pkg::*;
#(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         tx_en,
  input  logic         mode_quad,
  input  logic [W-1:0] din,
  output logic         vld_n,
  output logic [W-1:0] i_n,
  output logic [W-1:0] q_n,
  output logic         err_n
);
  iqa_slot_e    slot_q, slot_d;
  logic         fl_q, fl_d;
  logic [W-1:0] hold_q, hold_d;

  always_comb begin
    slot_d = slot_q;
    fl_d   = fl_q;
    hold_d = hold_q;
    vld_n  = 1'b0;
    i_n    = '0;
    q_n    = '0;
    err_n  = 1'b0;
    if (!tx_en) begin
      err_n  = (slot_q == SLOT_Q);
      slot_d = SLOT_I;
      hold_d = '0;
      if (mode_quad) begin
        if (tick) begin
          fl_d  = ~fl_q;
          vld_n = fl_q;
        end
      end else begin
        fl_d  = 1'b0;
        vld_n = tick;
      end
    end else begin
      fl_d = 1'b0;
      if (tick) begin
        if (!mode_quad) begin
          vld_n  = 1'b1;
          i_n    = din;
          slot_d = SLOT_I;
        end else if (slot_q == SLOT_I) begin
          hold_d = din;
          slot_d = SLOT_Q;
        end else begin
          vld_n  = 1'b1;
          i_n    = hold_q;
          q_n    = din;
          slot_d = SLOT_I;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= SLOT_I;
      fl_q   <= 1'b0;
      hold_q <= '0;
    end else begin
      slot_q <= slot_d;
      fl_q   <= fl_d;
      hold_q <= hold_d;
    end
  end

  // R4: a window always opens on the I slot
  assert_first_is_i_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> (slot_q == SLOT_I));

  // R6: nothing but zeros leaves while disabled
  assert_flush_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_n && !tx_en) |-> (i_n == '0 && q_n == '0));

  // R5: the Q path is silent in interpolating mode
  assert_interp_q_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_n && !mode_quad) |-> (q_n == '0));
endmodule

// File: rtl/iqa_out_reg.sv
module iqa_out_reg #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld_n,
  input  logic [W-1:0] i_n,
  input  logic [W-1:0] q_n,
  input  logic         err_n,
  output logic         vld_o,
  output logic [W-1:0] i_o,
  output logic [W-1:0] q_o,
  output logic         err_o
);
  logic         load_en;
  logic [W-1:0] i_d, q_d;

  always_comb begin
    load_en = vld_n;
    i_d     = load_en ? i_n : i_o;
    q_d     = load_en ? q_n : q_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
      err_o <= 1'b0;
      i_o   <= '0;
      q_o   <= '0;
    end else begin
      vld_o <= vld_n;
      err_o <= err_n;
      i_o   <= i_d;
      q_o   <= q_d;
    end
  end

  // R8: pair fields hold without a strobe
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_o |-> ($stable(i_o) && $stable(q_o)));
endmodule

// File: rtl/iq_input_assembler.sv
module iq_input_assembler #(
  parameter int W     = 14,
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_ratio,
  input  logic             lock_qual,
  input  logic             pll_locked,
  input  logic             mode_quad,
  input  logic             tx_en,
  input  logic [W-1:0]     din,
  output logic             dclk_en,
  output logic [W-1:0]     pair_i,
  output logic [W-1:0]     pair_q,
  output logic             pair_vld,
  output logic             pair_err
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_n_s;
  logic                   tick;
  logic                   vld_n, err_n;
  logic [W-1:0]           i_n, q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_s = rst_pipe[SYNC_STAGES-1];

  iqa_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .div_ratio  (div_ratio),
    .lock_qual  (lock_qual),
    .pll_locked (pll_locked),
    .tick_o     (tick)
  );

  iqa_demux #(.W(W)) u_demux (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .tick      (tick),
    .tx_en     (tx_en),
    .mode_quad (mode_quad),
    .din       (din),
    .vld_n     (vld_n),
    .i_n       (i_n),
    .q_n       (q_n),
    .err_n     (err_n)
  );

  iqa_out_reg #(.W(W)) u_out (
    .clk   (clk),
    .rst_n (rst_n_s),
    .vld_n (vld_n),
    .i_n   (i_n),
    .q_n   (q_n),
    .err_n (err_n),
    .vld_o (pair_vld),
    .i_o   (pair_i),
    .q_o   (pair_q),
    .err_o (pair_err)
  );

  assign dclk_en = tick;

  // R3: the strobe is one cycle wide
  assert_strobe_width_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    pair_vld |=> !pair_vld);

  // R7: the error flag lasts a single cycle
  assert_err_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    pair_err |=> !pair_err);
endmodule

// File: tb/iq_input_assembler_bench.sv
module iq_input_assembler_bench;
  localparam int W      = 14;
  localparam int DIV_W  = 6;
  localparam int CLK_NS = 10;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [DIV_W-1:0] div_ratio;
  logic             lock_qual, pll_locked, mode_quad, tx_en;
  logic [W-1:0]     din;
  logic             dclk_en, pair_vld, pair_err;
  logic [W-1:0]     pair_i, pair_q;

  int total = 0;
  int bad   = 0;

  int           ecnt;
  bit           eph, efl;
  logic [W-1:0] ehold, ri, rq;
  bit           exp_vld, exp_err, have_exp;
  string        exp_tag;
  bit           after_err;
  int           err_seen, r4_hits;

  always #(CLK_NS/2) clk = ~clk;

  iq_input_assembler #(.W(W), .DIV_W(DIV_W)) u_iq_input_assembler (
    .clk(clk), .rst_n(rst_n), .div_ratio(div_ratio), .lock_qual(lock_qual),
    .pll_locked(pll_locked), .mode_quad(mode_quad), .tx_en(tx_en), .din(din),
    .dclk_en(dclk_en), .pair_i(pair_i), .pair_q(pair_q),
    .pair_vld(pair_vld), .pair_err(pair_err)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  function automatic bit exp_tick();
    return (ecnt >= int'(div_ratio)) && (!lock_qual || pll_locked);
  endfunction

  // predict next-cycle outputs from the current inputs and model state
  task automatic step();
    bit t;
    t = exp_tick();
    check(dclk_en == t, (lock_qual && !pll_locked) ? "R2" : "R1", "dclk_en",
          int'(dclk_en), int'(t));
    exp_vld = 0;
    exp_err = 0;
    exp_tag = "R8";
    if (!tx_en) begin
      if (eph) begin exp_err = 1; after_err = 1; end
      eph = 0;
      if (mode_quad) begin
        if (t) begin
          exp_vld = efl;
          efl     = !efl;
        end
      end else begin
        efl     = 0;
        exp_vld = t;
      end
      if (exp_vld) begin ri = '0; rq = '0; exp_tag = "R6"; end
    end else begin
      efl = 0;
      if (t) begin
        if (!mode_quad) begin
          exp_vld = 1; ri = din; rq = '0; exp_tag = "R5"; eph = 0;
        end else if (!eph) begin
          ehold = din; eph = 1;
        end else begin
          exp_vld = 1; ri = ehold; rq = din; eph = 0;
          exp_tag = after_err ? "R4" : "R3";
          if (after_err) r4_hits++;
          after_err = 0;
        end
      end
    end
    ecnt = (ecnt >= int'(div_ratio)) ? 0 : ecnt + 1;
    have_exp = 1;
  endtask

  task automatic compare();
    if (!have_exp) return;
    check(pair_vld == exp_vld, exp_tag, "pair_vld", int'(pair_vld), int'(exp_vld));
    check(pair_i == ri, exp_tag, "pair_i", int'(pair_i), int'(ri));
    check(pair_q == rq, exp_tag, "pair_q", int'(pair_q), int'(rq));
    check(pair_err == exp_err, "R7", "pair_err", int'(pair_err), int'(exp_err));
    if (pair_err) err_seen++;
  endtask

  task automatic run_segment(input logic [DIV_W-1:0] dv, input int cycles);
    int k;
    rst_n = 0; div_ratio = dv; lock_qual = 0; pll_locked = 0;
    mode_quad = 1; tx_en = 0; din = '0; have_exp = 0;
    repeat (3) @(negedge clk);
    check(!dclk_en && !pair_vld && !pair_err && pair_i == '0 && pair_q == '0,
          "R9", "reset outputs", int'({dclk_en, pair_vld, pair_err}), 0);
    rst_n = 1;
    k = 0;
    do begin @(negedge clk); k++; end while (!pair_vld && k < 200);
    check(pair_vld && pair_i == '0 && pair_q == '0, "R6", "initial flush pair",
          int'(pair_vld), 1);
    ecnt = 0; efl = 0; eph = 0; ri = '0; rq = '0; after_err = 0;
    for (int c = 0; c < cycles; c++) begin
      if (c > 0) begin
        @(negedge clk);
        compare();
      end
      din = W'($urandom);
      if ($urandom_range(0, 7) == 0) tx_en = !tx_en;
      if (!tx_en && $urandom_range(0, 30) == 0) mode_quad = !mode_quad;
      if (c > cycles / 2 && c < (cycles * 3) / 4) begin
        lock_qual = 1;
        if ($urandom_range(0, 9) == 0) pll_locked = !pll_locked;
      end else begin
        lock_qual = 0;
        pll_locked = W'($urandom) % 2 == 1;
      end
      #1;
      step();
    end
    @(negedge clk);
    compare();
  endtask

  initial begin
    int seed_val;
    seed_val = $urandom(32'h1d2c3b4a);
    // directed: fixed divide of 3, then 5, each with random windows
    run_segment(6'd3, 4000);
    run_segment(6'd5, 4000);
    check(err_seen > 0, "R7", "unpaired I drops observed", err_seen, 1);
    check(r4_hits > 0, "R4", "windows after a drop observed", r4_hits, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule